// File: doc/BRIEF.md
# Return Address Stack Controller

This block keeps the return linkage for a small processor whose program address is 13 bits wide. When a call executes, the controller writes the current program counter into a private register-file array. When a return executes, it drops that entry. Its top-of-stack output is one of the candidate next addresses that the address source selector can load into the program address registers. The array is addressed by a dedicated wrapping up/down pointer. An occupancy counter beside the pointer drives the full and empty flags.

The consumer reads `tos_o` in the same cycle it raises `pop_i`. On that clock edge the pointer steps back, and `tos_o` then shows the entry below. Overflow and underflow are defined cases, not undefined ones. A push into a full stack overwrites the oldest entry. A pop from an empty stack moves the pointer back anyway. Each case sets its own sticky flag, which only reset clears.

Top module: `ras_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), `empty_o`=1, `full_o`=0, `ovf_o`=0 and `udf_o`=0.
- R2: A push alone (`push_i`=1, `pop_i`=0) stores `pc_i`. From the next cycle `tos_o` equals that value, and the occupancy rises by one unless the stack is already full.
- R3: A pop alone (`pop_i`=1, `push_i`=0) on a non-empty stack lowers the occupancy by one. From the next cycle `tos_o` shows the entry pushed before the popped one (last in, first out).
- R4: `empty_o` is 1 exactly when the occupancy is 0. `full_o` is 1 exactly when the occupancy equals DEPTH (16). The two are never 1 together.
- R5: A push alone on a full stack overwrites the oldest entry and keeps the occupancy at DEPTH. It sets `ovf_o`, which stays 1 until reset.
- R6: A pop alone on an empty stack keeps the occupancy at 0 and moves the pointer back by one, wrapping modulo DEPTH. It sets `udf_o`, which stays 1 until reset.
- R7: Push and pop together on a non-empty stack replace the top entry with `pc_i` and leave the occupancy unchanged. On an empty stack the pair acts as a plain push.
- R8: With neither strobe high, the occupancy, flags and `tos_o` hold their values.
- R9: `tos_o` always reads the slot just below the pointer. Reset does not clear the storage, so right after reset `tos_o` shows what slot DEPTH-1 last held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Call strobe: save `pc_i` |
| pop_i | input | 1 | Return strobe: drop the top entry |
| pc_i | input | 13 | Program counter to save |
| tos_o | output | 13 | Current top entry (return address candidate) |
| empty_o | output | 1 | Occupancy is zero |
| full_o | output | 1 | Occupancy equals DEPTH |
| ovf_o | output | 1 | Sticky: a push hit a full stack |
| udf_o | output | 1 | Sticky: a pop hit an empty stack |

## Verification
The embedded properties check these behaviours on every cycle:
- each strobe combination moves the occupancy by the right step,
- the overflow and underflow flags rise on the matching pushes and pops and then stay set,
- `tos_o` shows a freshly pushed or replaced value one cycle later,
- the state holds when idle,
- full and empty are never high together.

Some behaviours need stored history, so only the bench's reference model can show them:
- the LIFO order of long push and pop runs,
- the loss of exactly the oldest entries after an overflow,
- the pointer wrap after an underflow,
- the storage surviving a reset.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      RAS_IDLE = 2'b00,
      RAS_PUSH = 2'b01,
      RAS_POP  = 2'b10,
      RAS_SWAP = 2'b11
   } ras_op_e;

   function automatic ras_op_e ras_decode(input logic push, input logic pop);
      return ras_op_e'({pop, push});
   endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
   import ras_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  ras_op_e          op_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [PTR_W-1:0] wr_idx_o,
   output logic             wr_en_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             ovf_o,
   output logic             udf_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

   logic [PTR_W-1:0] ptr_q, ptr_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ovf_q, ovf_d, udf_q, udf_d;
   logic             is_empty, is_full;

   assign is_empty = (cnt_q == '0);
   assign is_full  = (cnt_q == CNT_FULL);

   always_comb begin
      ptr_d    = ptr_q;
      cnt_d    = cnt_q;
      ovf_d    = ovf_q;
      udf_d    = udf_q;
      wr_en_o  = 1'b0;
      wr_idx_o = ptr_q;
      unique case (op_i)
         RAS_PUSH: begin
            wr_en_o = 1'b1;
            ptr_d   = ptr_q + PTR_ONE;
            if (is_full) ovf_d = 1'b1;
            else         cnt_d = cnt_q + 1'b1;
         end
         RAS_POP: begin
            ptr_d = ptr_q - PTR_ONE;
            if (is_empty) udf_d = 1'b1;
            else          cnt_d = cnt_q - 1'b1;
         end
         RAS_SWAP: begin
            wr_en_o = 1'b1;
            if (is_empty) begin
               ptr_d = ptr_q + PTR_ONE;
               cnt_d = cnt_q + 1'b1;
            end else begin
               wr_idx_o = ptr_q - PTR_ONE;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ptr_q <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ptr_q <= ptr_d;
         cnt_q <= cnt_d;
         ovf_q <= ovf_d;
         udf_q <= udf_d;
      end
   end

   assign ptr_o   = ptr_q;
   assign empty_o = is_empty;
   assign full_o  = is_full;
   assign ovf_o   = ovf_q;
   assign udf_o   = udf_q;

   p_push_count_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == RAS_PUSH && !is_full) |=> cnt_q == $past(cnt_q) + 1'b1);
   p_pop_count_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == RAS_POP && !is_empty) |=> cnt_q == $past(cnt_q) - 1'b1);
   p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !(empty_o && full_o));
   p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == RAS_PUSH && is_full) |=> (ovf_o && full_o));
   p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      ovf_o |=> ovf_o);
   p_underflow_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == RAS_POP && is_empty) |=> (udf_o && empty_o && ptr_q == $past(ptr_q) - PTR_ONE));
   p_udf_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      udf_o |=> udf_o);
   p_swap_count_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == RAS_SWAP && !is_empty) |=> $stable(cnt_q) && $stable(ptr_q));
   p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == RAS_IDLE) |=> $stable(cnt_q) && $stable(ptr_q) && $stable(ovf_q) && $stable(udf_q));

endmodule

// File: rtl/ras_regfile.sv
module ras_regfile #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 13,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (wr_en_i && wr_idx_i == IDX_W'(g)) slot_q[g] <= wr_data_i;
      end
   end

   assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
   import ras_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DEPTH  = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] tos_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              ovf_o,
   output logic              udf_o
);

   localparam int PTR_W = $clog2(DEPTH);

   if (ADDR_W < 1) begin : g_bad_width
      $error("ras_ctrl: ADDR_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ras_ctrl: DEPTH must be a power of two, at least 2");
   end

   ras_op_e          op;
   logic [PTR_W-1:0] ptr, wr_idx, rd_idx;
   logic             wr_en;

   assign op     = ras_decode(push_i, pop_i);
   assign rd_idx = ptr - PTR_W'(1);

   ras_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .op_i     (op),
      .ptr_o    (ptr),
      .wr_idx_o (wr_idx),
      .wr_en_o  (wr_en),
      .empty_o  (empty_o),
      .full_o   (full_o),
      .ovf_o    (ovf_o),
      .udf_o    (udf_o)
   );

   ras_regfile #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_store (
      .clk_i     (clk_i),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (pc_i),
      .rd_idx_i  (rd_idx),
      .rd_data_o (tos_o)
   );

   p_push_tos_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (push_i && !pop_i) |=> tos_o == $past(pc_i));
   p_swap_tos_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (push_i && pop_i) |=> tos_o == $past(pc_i));
   p_idle_tos_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!push_i && !pop_i) |=> $stable(tos_o));

endmodule

// File: tb/ras_ctrl_tb_top.sv
module ras_ctrl_tb_top;

   localparam int AW = 13;
   localparam int D  = 16;

   logic          clk = 1'b0;
   logic          rst, push, pop;
   logic [AW-1:0] pc;
   logic [AW-1:0] tos;
   logic          empty, full, ovf, udf;

   always #4 clk = ~clk;

   ras_ctrl #(.ADDR_W(AW), .DEPTH(D)) dut_i (
      .clk_i(clk), .rst_i(rst), .push_i(push), .pop_i(pop), .pc_i(pc),
      .tos_o(tos), .empty_o(empty), .full_o(full), .ovf_o(ovf), .udf_o(udf)
   );

   int    checks = 0, fails = 0;
   int    m_ptr = 0, m_cnt = 0;
   bit    m_ovf = 0, m_udf = 0, armed = 0;
   int    m_mem [D];
   bit    m_val [D];
   string tag = "R1";

   task automatic chk(input string t, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   task automatic compare();
      int top;
      top = (m_ptr + D - 1) % D;
      chk("R4", int'(empty), int'(m_cnt == 0));
      chk("R4", int'(full), int'(m_cnt == D));
      chk(tag, int'(ovf), int'(m_ovf));
      chk(tag, int'(udf), int'(m_udf));
      if (m_val[top]) chk(tag, int'(tos), m_mem[top]);
   endtask

   task automatic model(input bit r, input bit pu, input bit po, input int v);
      if (r) begin
         m_ptr = 0; m_cnt = 0; m_ovf = 0; m_udf = 0;
         tag = m_val[D-1] ? "R9" : "R1";
      end else if (pu && po && m_cnt > 0) begin
         m_mem[(m_ptr + D - 1) % D] = v;
         tag = "R7";
      end else if (pu) begin
         m_mem[m_ptr] = v; m_val[m_ptr] = 1;
         m_ptr = (m_ptr + 1) % D;
         if (po) begin m_cnt++; tag = "R7"; end
         else if (m_cnt == D) begin m_ovf = 1; tag = "R5"; end
         else begin m_cnt++; tag = "R2"; end
      end else if (po) begin
         m_ptr = (m_ptr + D - 1) % D;
         if (m_cnt == 0) begin m_udf = 1; tag = "R6"; end
         else begin m_cnt--; tag = "R3"; end
      end else tag = "R8";
   endtask

   task automatic step(input bit r, input bit pu, input bit po, input int v);
      @(negedge clk);
      if (armed) compare();
      rst = r; push = pu; pop = po; pc = AW'(v);
      model(r, pu, po, v);
      armed = 1;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) begin m_mem[i] = 0; m_val[i] = 0; end
      rst = 1; push = 0; pop = 0; pc = '0;
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);                                         // R1 reset state
      for (int i = 0; i < 5; i++) step(0, 1, 0, 100 + i);       // R2 pushes
      for (int i = 0; i < 3; i++) step(0, 0, 1, 0);             // R3 pops
      step(0, 1, 1, 4000);                                      // R7 replace
      step(0, 0, 0, 1234);                                      // R8 idle
      step(0, 0, 0, 77);
      for (int i = 0; i < 14; i++) step(0, 1, 0, 500 + i);      // R4 fill to full
      for (int i = 0; i < 3; i++) step(0, 1, 0, 8000 + i);      // R5 overflow
      step(0, 1, 1, 8191);                                      // R7 replace on full
      for (int i = 0; i < D; i++) step(0, 0, 1, 0);             // R3 drain
      for (int i = 0; i < 3; i++) step(0, 0, 1, 0);             // R6 underflow
      step(0, 1, 1, 321);                                       // R7 pair on empty
      step(0, 0, 0, 0);
      for (int i = 0; i < D; i++) step(0, 1, 0, 2000 + 7 * i);
      step(1, 0, 0, 0);                                         // R9 storage kept
      step(0, 0, 0, 0);
      for (int i = 0; i < 3000; i++) begin
         int sel;
         sel = int'($urandom_range(9, 0));
         step(sel == 9, sel < 5 || sel == 8, sel >= 5 && sel != 9, int'($urandom_range(8191, 0)));
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule